// File: doc/BRIEF.md
# Tagged Out-of-Order Completion Buffer

This block sits between one requester and one target that may finish its work in any order. Every request the block accepts is tagged with a transaction ID. The tag travels to the target with the request, and the target returns the same tag with its response. Each returned result is parked in a buffer slot chosen by its tag. Results are then handed to the consumer through a valid/ready port, strictly in the order the requests were accepted.

A pending counter limits the number of open transactions to `NUM_TAGS`. An optional spacing gate makes the request side wait a minimum number of cycles between acceptances. If the target returns a tag that is not awaiting a response, the block discards that response and raises a sticky error flag.

Top module: `ooo_tag_rob`

## Requirements
- R1: While the block is open (fewer than `NUM_TAGS` pending and no spacing stall), `tgt_req_valid_o` equals `req_valid_i`, `req_ready_o` equals `tgt_req_ready_i`, and `tgt_req_payload_o` equals `req_payload_i`. A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both high.
- R2: The ID on `tgt_req_id_o` is `$clog2(NUM_TAGS)` bits wide. It is 0 for the first request after reset and increases by one, wrapping modulo `NUM_TAGS`, after each accepted request. `NUM_TAGS` is a power of two.
- R3: A transaction stays pending from its acceptance until the consumer takes its result. While `NUM_TAGS` transactions are pending, `req_ready_o` and `tgt_req_valid_o` are low.
- R4: After each accepted request, `req_ready_o` and `tgt_req_valid_o` stay low for the next `SPACING-1` cycles.
- R5: A response whose ID is awaiting a response stores `tgt_resp_data_i` in the slot of that ID. Responses may arrive in any order.
- R6: `cons_valid_o` is high exactly when the oldest pending transaction has received its response. `cons_data_o` then carries that response's data. Results leave in acceptance order.
- R7: While `cons_valid_o` is high and `cons_ready_i` is low, `cons_valid_o` stays high and `cons_data_o` does not change in the next cycle.
- R8: A response whose ID is not awaiting a response sets `err_o` from the next cycle until reset. Its data is dropped, and no stored result changes.
- R9: A response and a consumer handshake that complete different transactions in the same cycle both take effect.
- R10: After reset, no transaction is pending, `cons_valid_o` and `err_o` are low, and the first ID is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Requester has a request |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_payload_i | input | REQ_W | Request payload |
| tgt_req_valid_o | output | 1 | Request offered to the target |
| tgt_req_ready_i | input | 1 | Target can take a request |
| tgt_req_payload_o | output | REQ_W | Payload forwarded to the target |
| tgt_req_id_o | output | $clog2(NUM_TAGS) | Transaction ID for the offered request |
| tgt_resp_valid_i | input | 1 | Target returns a response |
| tgt_resp_id_i | input | $clog2(NUM_TAGS) | ID of the returned response |
| tgt_resp_data_i | input | DATA_W | Response data |
| cons_valid_o | output | 1 | Oldest result is ready |
| cons_ready_i | input | 1 | Consumer takes the result |
| cons_data_o | output | DATA_W | Oldest result data |
| err_o | output | 1 | Sticky stray-response flag |

## Verification
The bench runs a target model that answers pending IDs in random order, including answers in the same cycle as a retirement. A design that indexed storage by arrival order, instead of by ID, would hand out the wrong data. A design that lost one of two simultaneous events would hang or drop a result. The bench fills every tag with the consumer stalled, to catch a counter that lets a fifth request through and so reuses a live ID. It also holds the consumer off to check that the output stays stable under backpressure. Finally, it sends a stray response aimed at a slot that holds an unread result. A design that wrote the stray data would return corrupted data, and one without the flag would leave `err_o` low.

// File: rtl/ooo_rob_pkg.sv
package ooo_rob_pkg;
  function automatic int unsigned id_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ooo_rob_issue.sv
module ooo_rob_issue #(
  parameter int unsigned NUM_TAGS = 4,
  parameter int unsigned SPACING  = 1,
  parameter int unsigned ID_W     = 2,
  parameter int unsigned CNT_W    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            tgt_ready_i,
  input  logic            retire_i,
  output logic            req_ready_o,
  output logic            tgt_valid_o,
  output logic            fire_o,
  output logic [ID_W-1:0] id_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [ID_W-1:0]  id_q;
  logic             full, ii_open, open;

  assign full        = (cnt_q == CNT_W'(NUM_TAGS));
  assign open        = !full && ii_open;
  assign req_ready_o = tgt_ready_i && open;
  assign tgt_valid_o = req_valid_i && open;
  assign fire_o      = req_valid_i && tgt_ready_i && open;
  assign id_o        = id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      id_q  <= '0;
    end else begin
      if (fire_o && !retire_i)      cnt_q <= cnt_q + 1'b1;
      else if (!fire_o && retire_i) cnt_q <= cnt_q - 1'b1;
      if (fire_o) id_q <= id_q + 1'b1;
    end
  end

  generate
    if (SPACING > 1) begin : g_gap
      localparam int unsigned GAP_W = $clog2(SPACING);
      logic [GAP_W-1:0] gap_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            gap_q <= '0;
        else if (fire_o)        gap_q <= GAP_W'(SPACING - 1);
        else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
      end
      assign ii_open = (gap_q == '0);

      assert_ii_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |=> !fire_o);
    end else begin : g_nogap
      assign ii_open = 1'b1;
    end
  endgenerate

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_TAGS));
  assert_id_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> id_q == ID_W'($past(id_q) + 1'b1));
endmodule

// File: rtl/ooo_rob_slots.sv
module ooo_rob_slots #(
  parameter int unsigned NUM_TAGS = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [ID_W-1:0]   issue_id_i,
  input  logic              resp_valid_i,
  input  logic [ID_W-1:0]   resp_id_i,
  input  logic [DATA_W-1:0] resp_data_i,
  input  logic              retire_i,
  input  logic [ID_W-1:0]   rd_id_i,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o
);
  logic [NUM_TAGS-1:0] pend_q, done_q;
  logic [DATA_W-1:0]   data_q [NUM_TAGS];
  logic                hit, stray, err_q;

  assign hit   = resp_valid_i &&  pend_q[resp_id_i];
  assign stray = resp_valid_i && !pend_q[resp_id_i];

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_slot
    logic sel_issue, sel_resp, sel_ret;
    assign sel_issue = issue_i  && (issue_id_i == ID_W'(i));
    assign sel_resp  = hit      && (resp_id_i  == ID_W'(i));
    assign sel_ret   = retire_i && (rd_id_i    == ID_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
        data_q[i] <= '0;
      end else begin
        if (sel_issue)     pend_q[i] <= 1'b1;
        else if (sel_resp) pend_q[i] <= 1'b0;
        if (sel_resp) begin
          done_q[i] <= 1'b1;
          data_q[i] <= resp_data_i;
        end else if (sel_ret) begin
          done_q[i] <= 1'b0;
        end
      end
    end

    assert_store_by_id_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (resp_valid_i && resp_id_i == ID_W'(i) && pend_q[i])
      |=> (done_q[i] && data_q[i] == $past(resp_data_i)));
    assert_stray_keeps_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stray && resp_id_i == ID_W'(i) && done_q[i] && !sel_ret)
      |=> $stable(data_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (stray) err_q <= 1'b1;
  end

  assign err_o     = err_q;
  assign rd_done_o = done_q[rd_id_i];
  assign rd_data_o = data_q[rd_id_i];

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_no_double_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & done_q) == '0);
endmodule

// File: rtl/ooo_rob_retire.sv
module ooo_rob_retire #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              cons_ready_i,
  output logic [ID_W-1:0]   rd_id_o,
  output logic              retire_o,
  output logic              cons_valid_o,
  output logic [DATA_W-1:0] cons_data_o
);
  logic [ID_W-1:0] rd_q;

  assign rd_id_o      = rd_q;
  assign cons_valid_o = rd_done_i;
  assign cons_data_o  = rd_data_i;
  assign retire_o     = rd_done_i && cons_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_q <= '0;
    else if (retire_o) rd_q <= rd_q + 1'b1;
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_valid_o && !cons_ready_i) |=> (cons_valid_o && $stable(cons_data_o)));
endmodule

// File: rtl/ooo_tag_rob.sv
module ooo_tag_rob #(
  parameter int unsigned NUM_TAGS = 4,
  parameter int unsigned REQ_W    = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SPACING  = 1,
  localparam int unsigned ID_W    = ooo_rob_pkg::id_width(NUM_TAGS),
  localparam int unsigned CNT_W   = ID_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [REQ_W-1:0]  req_payload_i,
  output logic              tgt_req_valid_o,
  input  logic              tgt_req_ready_i,
  output logic [REQ_W-1:0]  tgt_req_payload_o,
  output logic [ID_W-1:0]   tgt_req_id_o,
  input  logic              tgt_resp_valid_i,
  input  logic [ID_W-1:0]   tgt_resp_id_i,
  input  logic [DATA_W-1:0] tgt_resp_data_i,
  output logic              cons_valid_o,
  input  logic              cons_ready_i,
  output logic [DATA_W-1:0] cons_data_o,
  output logic              err_o
);
  logic              fire, retire, rd_done;
  logic [ID_W-1:0]   rd_id;
  logic [DATA_W-1:0] rd_data;

  assign tgt_req_payload_o = req_payload_i;

  ooo_rob_issue #(
    .NUM_TAGS(NUM_TAGS), .SPACING(SPACING), .ID_W(ID_W), .CNT_W(CNT_W)
  ) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .tgt_ready_i (tgt_req_ready_i),
    .retire_i    (retire),
    .req_ready_o (req_ready_o),
    .tgt_valid_o (tgt_req_valid_o),
    .fire_o      (fire),
    .id_o        (tgt_req_id_o)
  );

  ooo_rob_slots #(
    .NUM_TAGS(NUM_TAGS), .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_slots (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (fire),
    .issue_id_i   (tgt_req_id_o),
    .resp_valid_i (tgt_resp_valid_i),
    .resp_id_i    (tgt_resp_id_i),
    .resp_data_i  (tgt_resp_data_i),
    .retire_i     (retire),
    .rd_id_i      (rd_id),
    .rd_done_o    (rd_done),
    .rd_data_o    (rd_data),
    .err_o        (err_o)
  );

  ooo_rob_retire #(
    .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_retire (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_done_i    (rd_done),
    .rd_data_i    (rd_data),
    .cons_ready_i (cons_ready_i),
    .rd_id_o      (rd_id),
    .retire_o     (retire),
    .cons_valid_o (cons_valid_o),
    .cons_data_o  (cons_data_o)
  );

  assert_ready_needs_target_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> tgt_req_ready_i);
endmodule

// File: tb/ooo_tag_rob_tb.sv
module ooo_tag_rob_tb_top;
  localparam int N  = 4;
  localparam int II = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, tgt_ready = 1'b0, resp_valid = 1'b0, cons_ready = 1'b0;
  logic [31:0] req_pay = '0, resp_data = '0;
  logic [1:0]  resp_id = '0;
  logic        req_ready, tgt_valid, cons_valid, err;
  logic [31:0] tgt_pay, cons_data;
  logic [1:0]  tgt_id;

  always #5 clk = ~clk;

  ooo_tag_rob #(.NUM_TAGS(N), .REQ_W(32), .DATA_W(32), .SPACING(II)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_payload_i(req_pay),
    .tgt_req_valid_o(tgt_valid), .tgt_req_ready_i(tgt_ready),
    .tgt_req_payload_o(tgt_pay), .tgt_req_id_o(tgt_id),
    .tgt_resp_valid_i(resp_valid), .tgt_resp_id_i(resp_id), .tgt_resp_data_i(resp_data),
    .cons_valid_o(cons_valid), .cons_ready_i(cons_ready), .cons_data_o(cons_data),
    .err_o(err)
  );

  int checks = 0, fails = 0;
  int ip = 0, hd = 0, inflight = 0, gap = 0;
  bit exp_err = 0;
  bit wt [N];
  bit ans [N];
  logic [31:0] pay [N];
  bit hold_pend = 0;
  logic [31:0] hold_data = '0;
  int ooo_cnt = 0, both_cnt = 0;
  bit done = 0;

  function automatic logic [31:0] resp_fn(input logic [31:0] p);
    return p * 32'd3 + 32'h1357;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit rv, input logic [31:0] rp, input bit tr,
                     input bit sv, input int sid, input logic [31:0] sdat, input bit cr);
    bit open, acc, ret, hitv;
    int oldest;
    @(negedge clk);
    req_valid = rv; req_pay = rp; tgt_ready = tr;
    resp_valid = sv; resp_id = sid[1:0]; resp_data = sdat; cons_ready = cr;
    #1;
    chk(err == exp_err, "R8", {31'd0, err}, {31'd0, exp_err});
    if (hold_pend) chk(cons_valid && cons_data == hold_data, "R7", cons_data, hold_data);
    open = (inflight < N) && (gap == 0);
    chk(req_ready == (tr && open), (inflight >= N) ? "R3" : (gap != 0) ? "R4" : "R1",
        {31'd0, req_ready}, {31'd0, tr && open});
    chk(tgt_valid == (rv && open), (inflight >= N) ? "R3" : (gap != 0) ? "R4" : "R1",
        {31'd0, tgt_valid}, {31'd0, rv && open});
    acc = rv && tr && open;
    if (acc) begin
      chk(tgt_id == ip[1:0], "R2", {30'd0, tgt_id}, ip);
      chk(tgt_pay == rp, "R1", tgt_pay, rp);
    end
    chk(cons_valid == ans[hd], "R6", {31'd0, cons_valid}, {31'd0, ans[hd]});
    ret = ans[hd] && cr;
    if (ans[hd]) chk(cons_data == resp_fn(pay[hd]), "R6", cons_data, resp_fn(pay[hd]));
    hold_pend = ans[hd] && !cr;
    hold_data = cons_data;
    hitv = sv && wt[sid];
    if (hitv) begin
      oldest = -1;
      for (int k = 0; k < N; k++) begin
        int j = (hd + k) % N;
        if (oldest < 0 && wt[j]) oldest = j;
      end
      if (oldest != sid) ooo_cnt++;
      if (ret) both_cnt++;  // R9 event pair
      wt[sid] = 0; ans[sid] = 1;
    end else if (sv) begin
      exp_err = 1;
    end
    if (ret) begin ans[hd] = 0; hd = (hd + 1) % N; end
    if (acc) begin pay[ip] = rp; wt[ip] = 1; ip = (ip + 1) % N; end
    inflight = inflight + int'(acc) - int'(ret);
    if (acc) gap = II - 1; else if (gap > 0) gap--;
  endtask

  function automatic int pick_wait(input int seed);
    for (int k = 0; k < N; k++) if (wt[(seed + k) % N]) return (seed + k) % N;
    return -1;
  endfunction

  initial begin
    #(10 * 200000);
    $display("FAIL watchdog actual=running expected=finished");
    fails++; checks++;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd1234));
    for (int k = 0; k < N; k++) begin wt[k] = 0; ans[k] = 0; pay[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tgt_ready = 1'b1;
    #1;
    // R10 reset state
    chk(!cons_valid, "R10", {31'd0, cons_valid}, 0);
    chk(!err, "R10", {31'd0, err}, 0);
    chk(req_ready, "R10", {31'd0, req_ready}, 1);
    chk(tgt_id == 2'd0, "R10", {30'd0, tgt_id}, 0);

    // R3: fill all tags with consumer stalled
    for (int k = 0; k < 12; k++) cyc(1, 32'h100 + k, 1, 0, 0, 0, 0);
    chk(inflight == N && !req_ready, "R3", {31'd0, req_ready}, 0);
    // R5: answer out of order
    cyc(0, 0, 1, 1, 2, resp_fn(pay[2]), 0);
    cyc(0, 0, 1, 1, 0, resp_fn(pay[0]), 0);
    cyc(0, 0, 1, 1, 3, resp_fn(pay[3]), 0);
    // R8: stray aimed at a slot holding an unread result
    cyc(0, 0, 1, 1, 0, 32'hDEAD_BEEF, 0);
    cyc(0, 0, 1, 0, 0, 0, 0);
    chk(err, "R8", {31'd0, err}, 1);
    // R9: retire slot 0 while slot 1 answers
    cyc(0, 0, 1, 1, 1, resp_fn(pay[1]), 1);
    for (int k = 0; k < 6; k++) cyc(0, 0, 1, 0, 0, 0, 1);
    chk(inflight == 0 && !cons_valid, "R6", {31'd0, cons_valid}, 0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int s;
      bit sv;
      r = pick_wait(int'($urandom_range(0, N - 1)));
      sv = (r >= 0) && ($urandom_range(0, 99) < 45);
      s = (r >= 0) ? r : 0;
      cyc($urandom_range(0, 99) < 70, $urandom(), $urandom_range(0, 99) < 80,
          sv, s, resp_fn(pay[s]), $urandom_range(0, 99) < 60);
    end
    // drain
    for (int c = 0; c < 40 && inflight > 0; c++) begin
      r = pick_wait(0);
      cyc(0, 0, 1, r >= 0, (r >= 0) ? r : 0, resp_fn(pay[(r >= 0) ? r : 0]), 1);
    end
    chk(inflight == 0, "R6", inflight, 0);
    chk(ooo_cnt > 0, "R5", ooo_cnt, 1);
    chk(both_cnt > 0, "R9", both_cnt, 1);
    chk(err, "R8", {31'd0, err}, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule